// File: doc/BRIEF.md
# Write-Update Snooping Cache Pair

This block holds two small direct-mapped write-back data caches, one for each of two processors, joined by one snooping bus. Coherence is kept by write-update. A processor store to a block that the other cache also holds sends only the stored word and its address across the bus. The other cache patches that word in its copy, and its line stays valid. A store to a block that only the local cache holds stays local. Loads that hit never use the bus.

On a miss the cache can first write back a dirty victim. It then fills the block one word per bus transfer. A fill takes its data from the other cache when that cache holds the block, and from memory otherwise. Both caches record in a per-line shared bit that the block now lives in two places. A fixed-priority arbiter orders bus use, and a counter reports how many one-word transfers have crossed the bus.

Top module: `wu_coherent_pair`

## Requirements
- R1: Addresses are byte addresses of 4-byte words. Word address = addr[ADDR_W-1:2], and a block holds WPB consecutive words (default 4). Byte addresses 100, 104 and 108 therefore share the block based at 96, and after one fill all three hit.
- R2: A load that hits raises cpu_done_o one clock after the request is first seen, with the word on cpu_rdata_o, and causes no bus transfer.
- R3: A store that hits a line whose shared bit is clear updates the line locally, completes one clock after the request, and causes no bus transfer.
- R4: A store that hits a shared line makes exactly one bus transfer carrying the word and its address, completes two clocks after the request, and causes no memory write.
- R5: When a cache holds a block named by another cache's update, it overwrites only the addressed word and keeps the line valid. Later loads of that word hit with the new value, and the other words of the block keep their old values.
- R6: A miss fills the block with WPB one-word transfers. Each word comes from the other cache when that cache holds the block (no memory access), otherwise from memory (mem_req_o high, mem_we_o low). Afterwards both copies are marked shared.
- R7: A miss whose victim line is dirty first writes the victim back with WPB transfers carrying mem_we_o high, then fills the block.
- R8: When both caches request the bus in the same cycle, cache 0 is granted. At most one grant is active per cycle, and a grant goes only to a requester.
- R9: bus_xfers_o increases by one for every granted bus cycle and holds otherwise.
- R10: After reset cpu_done_o and mem_req_o are low, bus_xfers_o is zero and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | N_CPU | Per-processor access request, held until done |
| cpu_we_i | input | N_CPU | Per-processor store (1) or load (0) |
| cpu_addr_i | input | N_CPU x ADDR_W | Per-processor byte address |
| cpu_wdata_i | input | N_CPU x 32 | Per-processor store data |
| cpu_done_o | output | N_CPU | One-cycle completion pulse |
| cpu_rdata_o | output | N_CPU x 32 | Load result, valid with done |
| mem_req_o | output | 1 | Memory access strobe for this bus cycle |
| mem_we_o | output | 1 | Memory write (write-back) |
| mem_waddr_o | output | ADDR_W-2 | Memory word address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Memory read data, combinational to mem_waddr_o |
| bus_xfers_o | output | XFER_W | Count of one-word bus transfers |

## Verification
The assertions assume that each processor holds its request, address and data steady until it sees cpu_done_o, and drops the request in that same cycle. They also assume that the two processors never aim at the same block while one of them is in the middle of filling it. The bench drives every request on the falling edge and releases it as soon as done is seen. The only simultaneous accesses it makes target different blocks, so a fill never races a snoop of the same block. Memory reads are modeled combinationally from mem_waddr_o, as the fill path expects.

// File: rtl/wu_pkg.sv
package wu_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_UPD  = 2'd1,
    BK_FILL = 2'd2,
    BK_WB   = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_UPD  = 2'd1,
    S_WB   = 2'd2,
    S_FILL = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/wu_bus_arb.sv
module wu_bus_arb #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;  // lowest index wins
    end
  end

  assert_gnt_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/wu_xfer_cnt.sv
module wu_xfer_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/wu_cache_ctl.sv
module wu_cache_ctl
  import wu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WPB    = 4,
  parameter int SETS   = 8,
  localparam int WADDR_W = ADDR_W - 2,
  localparam int IDX_W   = $clog2(SETS),
  localparam int OFF_W   = $clog2(WPB),
  localparam int TAG_W   = WADDR_W - OFF_W - IDX_W,
  localparam int CNT_W   = (OFF_W > 0) ? OFF_W : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic               cpu_done_o,
  output logic [DATA_W-1:0]  cpu_rdata_o,
  output logic               bus_req_o,
  output bus_kind_e          bus_kind_o,
  output logic [WADDR_W-1:0] bus_waddr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic               bus_gnt_i,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  input  logic               bus_shd_i,
  input  logic               snp_valid_i,
  input  bus_kind_e          snp_kind_i,
  input  logic [WADDR_W-1:0] snp_waddr_i,
  input  logic [DATA_W-1:0]  snp_wdata_i,
  output logic               snp_hit_o,
  output logic [DATA_W-1:0]  snp_rdata_o
);
  ctl_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic peer_q;
  logic [SETS-1:0] valid_q, dirty_q, shared_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [DATA_W-1:0] data_q [SETS][WPB];

  logic [WADDR_W-1:0] cpu_wa, wb_wa, fill_wa;
  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic [CNT_W-1:0] cpu_off, snp_off;
  logic hit, last, unused_byte;

  assign unused_byte = ^cpu_addr_i[1:0];
  assign cpu_wa  = cpu_addr_i[ADDR_W-1:2];
  assign cpu_idx = cpu_wa[OFF_W +: IDX_W];
  assign cpu_tag = cpu_wa[WADDR_W-1 -: TAG_W];
  assign snp_idx = snp_waddr_i[OFF_W +: IDX_W];
  assign snp_tag = snp_waddr_i[WADDR_W-1 -: TAG_W];

  if (OFF_W > 0) begin : g_multi
    assign cpu_off = cpu_wa[OFF_W-1:0];
    assign snp_off = snp_waddr_i[OFF_W-1:0];
    assign wb_wa   = {tag_q[cpu_idx], cpu_idx, cnt_q};
    assign fill_wa = {cpu_tag, cpu_idx, cnt_q};
  end else begin : g_single
    assign cpu_off = '0;
    assign snp_off = '0;
    assign wb_wa   = {tag_q[cpu_idx], cpu_idx};
    assign fill_wa = {cpu_tag, cpu_idx};
  end

  assign hit  = valid_q[cpu_idx] && (tag_q[cpu_idx] == cpu_tag);
  assign last = (cnt_q == CNT_W'(WPB - 1));

  assign snp_hit_o   = snp_valid_i && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign snp_rdata_o = data_q[snp_idx][snp_off];

  always_comb begin
    bus_req_o   = 1'b0;
    bus_kind_o  = BK_IDLE;
    bus_waddr_o = cpu_wa;
    bus_wdata_o = cpu_wdata_i;
    unique case (state_q)
      S_UPD:  begin bus_req_o = 1'b1; bus_kind_o = BK_UPD; end
      S_WB:   begin
        bus_req_o = 1'b1; bus_kind_o = BK_WB;
        bus_waddr_o = wb_wa; bus_wdata_o = data_q[cpu_idx][cnt_q];
      end
      S_FILL: begin bus_req_o = 1'b1; bus_kind_o = BK_FILL; bus_waddr_o = fill_wa; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      peer_q      <= 1'b0;
      cpu_done_o  <= 1'b0;
      cpu_rdata_o <= '0;
      valid_q     <= '0;
      dirty_q     <= '0;
      shared_q    <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        for (int w = 0; w < WPB; w++) data_q[s][w] <= '0;
      end
    end else begin
      cpu_done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cpu_req_i && !cpu_done_o) begin
          if (hit) begin
            if (!cpu_we_i) begin
              cpu_rdata_o <= data_q[cpu_idx][cpu_off];
              cpu_done_o  <= 1'b1;
            end else if (!shared_q[cpu_idx]) begin
              data_q[cpu_idx][cpu_off] <= cpu_wdata_i;
              dirty_q[cpu_idx] <= 1'b1;
              cpu_done_o <= 1'b1;
            end else begin
              state_q <= S_UPD;
            end
          end else begin
            cnt_q  <= '0;
            peer_q <= 1'b0;
            if (valid_q[cpu_idx] && dirty_q[cpu_idx]) begin
              state_q <= S_WB;
            end else begin
              valid_q[cpu_idx] <= 1'b0;  // no stale snoop hits while refilling
              state_q <= S_FILL;
            end
          end
        end
        S_UPD: if (bus_gnt_i) begin
          data_q[cpu_idx][cpu_off] <= cpu_wdata_i;
          dirty_q[cpu_idx] <= 1'b1;
          cpu_done_o <= 1'b1;
          state_q <= S_IDLE;
        end
        S_WB: if (bus_gnt_i) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last) begin
            cnt_q <= '0;
            valid_q[cpu_idx] <= 1'b0;
            dirty_q[cpu_idx] <= 1'b0;
            state_q <= S_FILL;
          end
        end
        S_FILL: if (bus_gnt_i) begin
          data_q[cpu_idx][cnt_q] <= bus_rdata_i;
          peer_q <= peer_q | bus_shd_i;
          cnt_q  <= cnt_q + CNT_W'(1);
          if (last) begin
            cnt_q <= '0;
            tag_q[cpu_idx]    <= cpu_tag;
            valid_q[cpu_idx]  <= 1'b1;
            dirty_q[cpu_idx]  <= 1'b0;
            shared_q[cpu_idx] <= peer_q | bus_shd_i;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
      // snooped traffic from the other cache
      if (snp_hit_o) begin
        if (snp_kind_i == BK_UPD)  data_q[snp_idx][snp_off] <= snp_wdata_i;
        if (snp_kind_i == BK_FILL) shared_q[snp_idx] <= 1'b1;
      end
    end
  end

  assert_upd_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_kind_o == BK_UPD) |=> cpu_done_o);
  assert_hit_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && cpu_req_i && !cpu_done_o && hit && !cpu_we_i) |=> !bus_req_o);
  assert_local_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && cpu_req_i && !cpu_done_o && hit && cpu_we_i && !shared_q[cpu_idx])
      |=> (!bus_req_o && cpu_done_o));
endmodule

// File: rtl/wu_coherent_pair.sv
module wu_coherent_pair
  import wu_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int ADDR_W = 16,
  parameter int WPB    = 4,
  parameter int SETS   = 8,
  parameter int XFER_W = 16,
  localparam int WADDR_W = ADDR_W - 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CPU-1:0]              cpu_req_i,
  input  logic [N_CPU-1:0]              cpu_we_i,
  input  logic [N_CPU-1:0][ADDR_W-1:0]  cpu_addr_i,
  input  logic [N_CPU-1:0][DATA_W-1:0]  cpu_wdata_i,
  output logic [N_CPU-1:0]              cpu_done_o,
  output logic [N_CPU-1:0][DATA_W-1:0]  cpu_rdata_o,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [WADDR_W-1:0]            mem_waddr_o,
  output logic [DATA_W-1:0]             mem_wdata_o,
  input  logic [DATA_W-1:0]             mem_rdata_i,
  output logic [XFER_W-1:0]             bus_xfers_o
);
  logic [N_CPU-1:0] req_w, gnt_w, snp_hit_w, snp_valid_w, peer_hit_w;
  bus_kind_e kind_w [N_CPU];
  logic [WADDR_W-1:0] waddr_w [N_CPU];
  logic [DATA_W-1:0] wdata_w [N_CPU], snp_data_w [N_CPU], peer_data_w [N_CPU], fill_w [N_CPU];

  bus_kind_e sel_kind;
  logic [WADDR_W-1:0] sel_wa;
  logic [DATA_W-1:0] sel_wd;
  logic sel_peer, any_gnt;

  assign any_gnt = |gnt_w;

  always_comb begin
    sel_kind = BK_IDLE;
    sel_wa   = '0;
    sel_wd   = '0;
    sel_peer = 1'b0;
    for (int i = 0; i < N_CPU; i++) begin
      if (gnt_w[i]) begin
        sel_kind = kind_w[i];
        sel_wa   = waddr_w[i];
        sel_wd   = wdata_w[i];
        sel_peer = peer_hit_w[i];
      end
    end
  end

  // per master: does some other cache hold the addressed block
  always_comb begin
    for (int i = 0; i < N_CPU; i++) begin
      peer_hit_w[i]  = 1'b0;
      peer_data_w[i] = '0;
      for (int j = 0; j < N_CPU; j++) begin
        if (j != i && snp_hit_w[j]) begin
          peer_hit_w[i]  = 1'b1;
          peer_data_w[i] = snp_data_w[j];
        end
      end
      fill_w[i] = peer_hit_w[i] ? peer_data_w[i] : mem_rdata_i;
    end
  end

  assign mem_req_o   = any_gnt && (sel_kind == BK_WB || (sel_kind == BK_FILL && !sel_peer));
  assign mem_we_o    = any_gnt && (sel_kind == BK_WB);
  assign mem_waddr_o = sel_wa;
  assign mem_wdata_o = sel_wd;

  for (genvar g = 0; g < N_CPU; g++) begin : g_cache
    assign snp_valid_w[g] = any_gnt && !gnt_w[g];
    wu_cache_ctl #(.ADDR_W(ADDR_W), .WPB(WPB), .SETS(SETS)) u_cache (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cpu_req_i   (cpu_req_i[g]),
      .cpu_we_i    (cpu_we_i[g]),
      .cpu_addr_i  (cpu_addr_i[g]),
      .cpu_wdata_i (cpu_wdata_i[g]),
      .cpu_done_o  (cpu_done_o[g]),
      .cpu_rdata_o (cpu_rdata_o[g]),
      .bus_req_o   (req_w[g]),
      .bus_kind_o  (kind_w[g]),
      .bus_waddr_o (waddr_w[g]),
      .bus_wdata_o (wdata_w[g]),
      .bus_gnt_i   (gnt_w[g]),
      .bus_rdata_i (fill_w[g]),
      .bus_shd_i   (peer_hit_w[g]),
      .snp_valid_i (snp_valid_w[g]),
      .snp_kind_i  (sel_kind),
      .snp_waddr_i (sel_wa),
      .snp_wdata_i (sel_wd),
      .snp_hit_o   (snp_hit_w[g]),
      .snp_rdata_o (snp_data_w[g])
    );
  end

  wu_bus_arb #(.N(N_CPU)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_w),
    .gnt_o  (gnt_w)
  );

  wu_xfer_cnt #(.W(XFER_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (any_gnt),
    .cnt_o  (bus_xfers_o)
  );
endmodule

// File: tb/tb_wu_coherent_pair.sv
module tb_wu_coherent_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [1:0] cpu_req = '0, cpu_we = '0, cpu_done;
  logic [1:0][15:0] cpu_addr = '0;
  logic [1:0][31:0] cpu_wdata = '0, cpu_rdata;
  logic mem_req, mem_we;
  logic [13:0] mem_waddr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [15:0] xfers;

  logic [31:0] mem [256];
  int mem_rd = 0, mem_wr = 0;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  wu_coherent_pair dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .bus_xfers_o(xfers)
  );

  assign mem_rdata = mem[mem_waddr[7:0]];

  initial for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | 32'(i);

  always @(posedge clk) begin
    if (mem_req && mem_we) begin mem[mem_waddr[7:0]] <= mem_wdata; mem_wr <= mem_wr + 1; end
    if (mem_req && !mem_we) mem_rd <= mem_rd + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input int c, input bit we, input logic [15:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_req[c] = 1'b1; cpu_we[c] = we; cpu_addr[c] = a; cpu_wdata[c] = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_done[c] && lat < 500);
    rd = cpu_rdata[c];
    cpu_req[c] = 1'b0; cpu_we[c] = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 done after reset", 32'(cpu_done), 32'd0);
    check("R10 xfers after reset", 32'(xfers), 32'd0);
    check("R10 mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_warm;
    logic [31:0] rd; int lat, x0, m0;
    x0 = xfers; m0 = mem_rd;
    access(0, 0, 16'd100, '0, rd, lat);
    check("R10 first access misses, data from memory", rd, 32'hA000_0019);
    check("R6 memory fill transfers", 32'(xfers - x0), 32'd4);
    check("R6 memory fill reads", 32'(mem_rd - m0), 32'd4);
    x0 = xfers; m0 = mem_rd;
    access(1, 0, 16'd104, '0, rd, lat);
    check("R6 peer fill data", rd, 32'hA000_001A);
    check("R6 peer fill transfers", 32'(xfers - x0), 32'd4);
    check("R6 peer fill touches no memory", 32'(mem_rd - m0), 32'd0);
  endtask

  task automatic t_update_seq;
    logic [31:0] rd; int lat, x0, w0;
    x0 = xfers; w0 = mem_wr;
    access(0, 1, 16'd100, 32'h1111_1111, rd, lat);
    check("R4 shared store latency", 32'(lat), 32'd2);
    check("R4 one transfer per shared store", 32'(xfers - x0), 32'd1);
    access(1, 1, 16'd104, 32'h2222_2222, rd, lat);
    access(0, 0, 16'd100, '0, rd, lat);
    check("R2 local read hit data", rd, 32'h1111_1111);
    check("R2 read hit latency", 32'(lat), 32'd1);
    access(1, 0, 16'd104, '0, rd, lat);
    check("R2 local read hit data p1", rd, 32'h2222_2222);
    access(0, 0, 16'd104, '0, rd, lat);
    check("R5 patched word seen by p0", rd, 32'h2222_2222);
    access(1, 0, 16'd100, '0, rd, lat);
    check("R5 patched word seen by p1", rd, 32'h1111_1111);
    access(1, 0, 16'd108, '0, rd, lat);
    check("R5 R1 neighbour word untouched", rd, 32'hA000_001B);
    check("R1 R9 whole sequence costs two transfers", 32'(xfers - x0), 32'd2);
    check("R4 updates write no memory", 32'(mem_wr - w0), 32'd0);
  endtask

  task automatic t_arbiter;
    logic [31:0] rd0, rd1; int lat0, lat1;
    fork
      access(0, 0, 16'd200, '0, rd0, lat0);
      access(1, 0, 16'd300, '0, rd1, lat1);
    join
    check("R8 cache 0 wins contention", 32'(lat0 < lat1), 32'd1);
    check("R8 data p0", rd0, 32'hA000_0032);
    check("R8 data p1", rd1, 32'hA000_004B);
  endtask

  task automatic t_local_write;
    logic [31:0] rd; int lat, x0;
    x0 = xfers;
    access(0, 1, 16'd200, 32'h3333_3333, rd, lat);
    check("R3 private store latency", 32'(lat), 32'd1);
    check("R3 private store no transfer", 32'(xfers - x0), 32'd0);
    access(0, 0, 16'd200, '0, rd, lat);
    check("R3 private store data", rd, 32'h3333_3333);
  endtask

  task automatic t_dirty_peer_fill;
    logic [31:0] rd; int lat, x0, m0;
    x0 = xfers; m0 = mem_rd;
    access(1, 0, 16'd200, '0, rd, lat);
    check("R6 dirty peer supplies data", rd, 32'h3333_3333);
    check("R6 dirty peer fill no memory", 32'(mem_rd - m0), 32'd0);
    check("R9 fill counted", 32'(xfers - x0), 32'd4);
  endtask

  task automatic t_evict;
    logic [31:0] rd; int lat, x0, w0;
    x0 = xfers; w0 = mem_wr;
    access(0, 0, 16'd320, '0, rd, lat);
    check("R7 refill data", rd, 32'hA000_0050);
    check("R7 write-back word count", 32'(mem_wr - w0), 32'd4);
    check("R7 R9 write-back plus fill transfers", 32'(xfers - x0), 32'd8);
    check("R7 dirty word reached memory", mem[50], 32'h3333_3333);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R2 watchdog cycles=%0d expected<=20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_warm();
    t_update_seq();
    t_arbiter();
    t_local_write();
    t_dirty_peer_fill();
    t_evict();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule